// File: doc/BRIEF.md
# Interval Timer with Three-Source Interrupt Combiner

This block pairs a down-counting interval timer with a small interrupt combiner. A CPU writes a 7-bit reload value and a run bit through a four-entry register window. While the timer runs, a prescaler divides the input clock into ticks of 1023 cycles. Each tick lowers the counter by one. When a tick arrives with the counter at zero, the counter reloads itself and latches a timer request. A reload value of N therefore gives one request every (N+1)×1023 cycles.

The combiner takes three sources: the latched timer request and two level requests from outside (video and expansion/break). A per-source blocking mask decides which of them may reach the single interrupt line to the CPU. Blocking a source only stops it from driving the interrupt line. Its pending bit still reads back as set. A write of any value to the status address acknowledges the timer request. That write has no effect on the counter.

Top module: `irq_timer_ctrl`

## Requirements
- R1: After reset the timer is stopped, the count reads 0, the mask reads 0, the timer request is clear and `irq_out` is 0 while both external inputs are low.
- R2: The first rollover after enabling comes (reload+1)×1023 cycles after the enabling write. Each later rollover comes (reload+1)×1023 cycles after the one before it. The count drops by one every 1023 cycles.
- R3: A reload value of 0 gives exactly 1023 cycles between rollovers.
- R4: Writing bit 0 = 0 to address 1 stops the timer, and the count and prescaler hold their values. A write of bit 0 = 1 while the timer is stopped loads the count from the reload value and restarts the prescaler from zero.
- R5: A rollover reloads the count and sets the timer request. A reload value written while the timer runs is first used at the next rollover.
- R6: A write of any data to address 3 clears only the timer request and does not change the count or the prescaler phase. If a rollover falls in the same cycle, the request stays set.
- R7: Mask bit 0 blocks the expansion source, bit 1 the video source and bit 2 the timer source. A 1 keeps that source off `irq_out`.
- R8: A read of address 3 returns bit 0 = expansion input, bit 1 = video input and bit 2 = timer request, with bits 7..3 zero, whatever the mask holds.
- R9: `irq_out` is 1 exactly when some source is pending and its mask bit is 0.
- R10: Register map. Address 0: a write sets the reload from bits 6..0 (bit 7 is ignored) and a read returns the current count. Address 1: bit 0 is the run bit and reads back. Address 2: bits 2..0 are the mask and read back, with the upper bits zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 2 | Register address (0 reload/count, 1 run, 2 mask, 3 status/ack) |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_sel`, combinational |
| video_irq_in | input | 1 | Video interrupt request, level |
| expn_irq_in | input | 1 | Expansion/break interrupt request, level |
| irq_out | output | 1 | Combined interrupt line to the CPU |

## Verification
A register write takes effect at the clock edge that samples it. The read data and `irq_out` follow that edge within the same cycle. The external levels and the mask reach `irq_out` and the status read with no register in the path. The timer request becomes visible just after the edge that ends the last 1023-cycle tick, which is (reload+1)×1023 edges after the enabling write. The bench updates its reference model at every rising edge and compares the model with the outputs 2 ns later. It measures rollover spacing as the count of edges between the first status reads that show the timer request.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

  typedef enum logic [1:0] {
    SEL_RELOAD = 2'd0,
    SEL_ENABLE = 2'd1,
    SEL_MASK   = 2'd2,
    SEL_STATUS = 2'd3
  } irqt_sel_e;

  localparam int SRC_EXP = 0;
  localparam int SRC_VID = 1;
  localparam int SRC_TMR = 2;
  localparam int NSRC    = 3;

  // true when any pending source is left unblocked
  function automatic logic any_unmasked(input logic [NSRC-1:0] pend,
                                        input logic [NSRC-1:0] blk);
    return |(pend & ~blk);
  endfunction

endpackage

// File: rtl/irqt_prescaler.sv
module irqt_prescaler #(
  parameter int TICK_LEN = 1023
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PW = (TICK_LEN > 1) ? $clog2(TICK_LEN) : 1;
  localparam logic [PW-1:0] LAST = PW'(TICK_LEN - 1);

  logic [PW-1:0] pre_q;

  assign tick = run && (pre_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (restart) begin
      pre_q <= '0;
    end else if (run) begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/irqt_down_counter.sv
module irqt_down_counter #(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  output logic [CNT_W-1:0] count,
  output logic             roll
);
  logic [CNT_W-1:0] count_q;

  // value after one tick: wrap to reload from zero, else step down
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] cur,
                                            input logic [CNT_W-1:0] rel);
    return (cur == '0) ? rel : cur - 1'b1;
  endfunction

  assign roll  = tick && (count_q == '0);
  assign count = count_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (load) begin
      count_q <= reload;
    end else if (tick) begin
      count_q <= step(count_q, reload);
    end
  end
endmodule

// File: rtl/irqt_regs.sv
module irqt_regs
  import irqt_pkg::*;
#(
  parameter int CNT_W  = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        sel,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count,
  input  logic [NSRC-1:0]   status,
  output logic [DATA_W-1:0] rdata,
  output logic [CNT_W-1:0]  reload_q,
  output logic              en_q,
  output logic [NSRC-1:0]   mask_q,
  output logic              load,
  output logic              ack
);
  irqt_sel_e sel_e;
  logic wr_reload, wr_enable, wr_mask;

  assign sel_e     = irqt_sel_e'(sel);
  assign wr_reload = we && (sel_e == SEL_RELOAD);
  assign wr_enable = we && (sel_e == SEL_ENABLE);
  assign wr_mask   = we && (sel_e == SEL_MASK);
  assign ack       = we && (sel_e == SEL_STATUS);
  assign load      = wr_enable && wdata[0] && !en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= '0;
      en_q     <= 1'b0;
      mask_q   <= '0;
    end else begin
      if (wr_reload) reload_q <= wdata[CNT_W-1:0];
      if (wr_enable) en_q     <= wdata[0];
      if (wr_mask)   mask_q   <= wdata[NSRC-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (sel_e)
      SEL_RELOAD: rdata = {{(DATA_W-CNT_W){1'b0}}, count};
      SEL_ENABLE: rdata = {{(DATA_W-1){1'b0}}, en_q};
      SEL_MASK:   rdata = {{(DATA_W-NSRC){1'b0}}, mask_q};
      SEL_STATUS: rdata = {{(DATA_W-NSRC){1'b0}}, status};
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irqt_intc.sv
module irqt_intc
  import irqt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exp_lvl,
  input  logic            vid_lvl,
  input  logic            tmr_set,
  input  logic            tmr_clr,
  input  logic [NSRC-1:0] mask,
  output logic [NSRC-1:0] status,
  output logic            irq
);
  logic            tmr_pend_q;
  logic [NSRC-1:0] raw;
  logic [NSRC-1:0] gated;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_pend_q <= 1'b0;
    end else if (tmr_set) begin
      tmr_pend_q <= 1'b1;
    end else if (tmr_clr) begin
      tmr_pend_q <= 1'b0;
    end
  end

  assign raw[SRC_EXP] = exp_lvl;
  assign raw[SRC_VID] = vid_lvl;
  assign raw[SRC_TMR] = tmr_pend_q;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign gated[i] = raw[i] & ~mask[i];
  end

  assign status = raw;
  assign irq    = any_unmasked(raw, mask) && (|gated);
endmodule

// File: rtl/irq_timer_ctrl.sv
module irq_timer_ctrl
  import irqt_pkg::*;
#(
  parameter int TICK_LEN = 1023,
  parameter int CNT_W    = 7,
  parameter int DATA_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        bus_sel,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              video_irq_in,
  input  logic              expn_irq_in,
  output logic              irq_out
);
  logic             tick_w;
  logic             roll_w;
  logic             load_w;
  logic             ack_w;
  logic             en_w;
  logic [CNT_W-1:0] reload_w;
  logic [CNT_W-1:0] count_w;
  logic [NSRC-1:0]  mask_w;
  logic [NSRC-1:0]  status_w;

  irqt_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(bus_sel), .we(bus_we), .wdata(bus_wdata),
    .count(count_w), .status(status_w), .rdata(bus_rdata),
    .reload_q(reload_w), .en_q(en_w), .mask_q(mask_w),
    .load(load_w), .ack(ack_w)
  );

  irqt_prescaler #(.TICK_LEN(TICK_LEN)) u_pre (
    .clk(clk), .rst_n(rst_n), .run(en_w), .restart(load_w), .tick(tick_w)
  );

  irqt_down_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load(load_w), .tick(tick_w),
    .reload(reload_w), .count(count_w), .roll(roll_w)
  );

  irqt_intc u_intc (
    .clk(clk), .rst_n(rst_n), .exp_lvl(expn_irq_in), .vid_lvl(video_irq_in),
    .tmr_set(roll_w), .tmr_clr(ack_w), .mask(mask_w),
    .status(status_w), .irq(irq_out)
  );
endmodule

// File: rtl/irqt_chk.sv
module irqt_chk #(
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             irq_out,
  input logic             expn_irq_in,
  input logic             video_irq_in,
  input logic             tick,
  input logic             roll,
  input logic             load,
  input logic             ack,
  input logic             en,
  input logic [CNT_W-1:0] count,
  input logic [2:0]       mask,
  input logic [2:0]       status
);
  // R9
  exp_reaches_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expn_irq_in && !mask[0]) |-> irq_out);

  // R9
  vid_reaches_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_irq_in && !mask[1]) |-> irq_out);

  // R7
  all_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b111) |-> !irq_out);

  // R5
  roll_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    roll |=> status[2]);

  // R6
  ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !roll) |=> !status[2]);

  // R4
  stopped_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(count));

  // R2
  count_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(count));

  // R2
  count_steps_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (count != '0)) |=> (count == $past(count) - CNT_W'(1)));
endmodule

bind irq_timer_ctrl irqt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_out(irq_out), .expn_irq_in(expn_irq_in),
  .video_irq_in(video_irq_in), .tick(tick_w), .roll(roll_w), .load(load_w),
  .ack(ack_w), .en(en_w), .count(count_w), .mask(mask_w), .status(status_w)
);

// File: tb/sim_irq_timer_ctrl.sv
module sim_irq_timer_ctrl;
  localparam int TL = 1023;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_sel = 2'd0;
  logic       bus_we = 1'b0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       video_irq_in = 1'b0;
  logic       expn_irq_in = 1'b0;
  logic       irq_out;

  always #4 clk = ~clk;

  irq_timer_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .video_irq_in(video_irq_in),
    .expn_irq_in(expn_irq_in), .irq_out(irq_out)
  );

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_wr = 0;
  bit check_on = 0;
  bit done = 0;

  // reference model: elapsed phase within the current period
  bit m_en;
  int m_reload, m_mask, m_pend, m_ph, m_per, m_start;

  always @(posedge clk) begin
    bit old_en;
    if (!rst_n) begin
      m_en = 0; m_reload = 0; m_mask = 0; m_pend = 0;
      m_ph = 0; m_per = TL; m_start = 0;
    end else begin
      cyc++;
      old_en = m_en;
      if (bus_we && bus_sel == 2'd3) m_pend = 0;
      if (old_en) begin
        m_ph++;
        if (m_ph == m_per) begin
          m_ph = 0; m_pend = 1; m_start = m_reload; m_per = (m_reload + 1) * TL;
        end
      end
      if (bus_we) begin
        case (bus_sel)
          2'd0: m_reload = int'(bus_wdata) % 128;
          2'd1: begin
            if (bus_wdata[0] && !old_en) begin
              m_ph = 0; m_start = m_reload; m_per = (m_reload + 1) * TL;
            end
            m_en = bus_wdata[0];
          end
          2'd2: m_mask = int'(bus_wdata) % 8;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("[TB] FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #2;
    if (rst_n && check_on) begin
      int src;
      int erd;
      src = m_pend * 4 + (video_irq_in ? 2 : 0) + (expn_irq_in ? 1 : 0);
      case (bus_sel)
        2'd0: begin erd = m_start - m_ph / TL; chk("R2 count", int'(bus_rdata), erd); end
        2'd1: begin erd = m_en ? 1 : 0;        chk("R10 run", int'(bus_rdata), erd); end
        2'd2: begin erd = m_mask;              chk("R10 mask", int'(bus_rdata), erd); end
        default: begin erd = src;              chk("R8 status", int'(bus_rdata), erd); end
      endcase
      chk("R9 irq", irq_out ? 1 : 0, ((src & ~m_mask & 7) != 0) ? 1 : 0);
    end
  end

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    bus_sel = s; bus_we = 1'b1; bus_wdata = d;
    @(posedge clk);
    #1 last_wr = cyc;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic setsel(input logic [1:0] s);
    @(negedge clk);
    bus_sel = s;
  endtask

  task automatic sample();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_tmr(output int at);
    setsel(2'd3);
    at = -1;
    for (int i = 0; i < 20000; i++) begin
      sample();
      if (bus_rdata[2]) begin at = cyc; break; end
    end
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      fails++; tests++;
      $display("[TB] FAIL watchdog: actual 0 expected 1 (run completed)");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int t1, t2, t3, t4, t5, t6, c0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check_on = 1;
    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      setsel(2'(s));
      sample();
      chk("R1 reg after reset", int'(bus_rdata), 0);
    end
    chk("R1 irq after reset", irq_out ? 1 : 0, 0);

    // R3 reload 0 gives 1023 cycles
    wr(2'd0, 8'd0);
    wr(2'd1, 8'd1);
    t1 = last_wr;
    wait_tmr(t2);
    chk("R3 first period reload 0", t2 - t1, TL);
    chk("R9 timer irq unmasked", irq_out ? 1 : 0, 1);
    wr(2'd3, 8'h5A);
    sample();
    chk("R6 ack clears timer", int'(bus_rdata[2]), 0);
    wait_tmr(t3);
    chk("R5 auto reload period", t3 - t2, TL);

    // R5 new reload used at the next rollover
    wr(2'd0, 8'd2);
    wr(2'd3, 8'd0);
    wait_tmr(t4);
    chk("R5 old reload still in force", t4 - t3, TL);
    wr(2'd3, 8'd0);
    wait_tmr(t5);
    chk("R2 period reload 2", t5 - t4, 3 * TL);

    // R6 ack mid-period does not restart the counter
    wr(2'd3, 8'd0);
    repeat (1500) @(posedge clk);
    setsel(2'd0);
    sample();
    chk("R2 count after one tick", int'(bus_rdata), 1);
    wr(2'd3, 8'hFF);
    setsel(2'd0);
    sample();
    chk("R6 count kept by ack", int'(bus_rdata), 1);
    wait_tmr(t6);
    chk("R6 period unchanged by ack", t6 - t5, 3 * TL);

    // R4 stop holds, restart loads
    wr(2'd3, 8'd0);
    repeat (500) @(posedge clk);
    wr(2'd1, 8'd0);
    setsel(2'd0);
    sample();
    c0 = int'(bus_rdata);
    repeat (4000) @(posedge clk);
    sample();
    chk("R4 count frozen while stopped", int'(bus_rdata), c0);
    setsel(2'd3);
    sample();
    chk("R4 no request while stopped", int'(bus_rdata[2]), 0);
    wr(2'd1, 8'd1);
    t1 = last_wr;
    setsel(2'd0);
    sample();
    chk("R4 restart loads reload", int'(bus_rdata), 2);
    wait_tmr(t2);
    chk("R4 period after restart", t2 - t1, 3 * TL);

    // R10 bit 7 of reload ignored, run readback
    wr(2'd1, 8'd0);
    wr(2'd3, 8'd0);
    wr(2'd0, 8'hFF);
    wr(2'd1, 8'hFF);
    setsel(2'd0);
    sample();
    chk("R10 reload bit 7 ignored", int'(bus_rdata), 127);
    setsel(2'd1);
    sample();
    chk("R10 run reads back", int'(bus_rdata), 1);
    wr(2'd1, 8'd0);
    wr(2'd0, 8'd0);

    // R7 R8 R9 masking
    @(negedge clk);
    expn_irq_in = 1'b1;
    setsel(2'd3);
    sample();
    chk("R8 expansion level in bit 0", int'(bus_rdata), 1);
    chk("R9 expansion drives irq", irq_out ? 1 : 0, 1);
    wr(2'd2, 8'h01);
    setsel(2'd3);
    sample();
    chk("R7 bit 0 blocks expansion", irq_out ? 1 : 0, 0);
    chk("R8 blocked source still visible", int'(bus_rdata), 1);
    @(negedge clk);
    video_irq_in = 1'b1;
    sample();
    chk("R9 video drives irq", irq_out ? 1 : 0, 1);
    wr(2'd2, 8'h03);
    setsel(2'd3);
    sample();
    chk("R7 bit 1 blocks video", irq_out ? 1 : 0, 0);
    chk("R8 both levels visible", int'(bus_rdata), 3);
    wr(2'd1, 8'd1);
    wait_tmr(t3);
    chk("R9 timer drives irq past mask 3", irq_out ? 1 : 0, 1);
    wr(2'd2, 8'hFF);
    setsel(2'd3);
    sample();
    chk("R7 bit 2 blocks timer", irq_out ? 1 : 0, 0);
    chk("R8 all three pending", int'(bus_rdata), 7);
    setsel(2'd2);
    sample();
    chk("R10 mask upper bits zero", int'(bus_rdata), 7);
    @(negedge clk);
    expn_irq_in = 1'b0;
    video_irq_in = 1'b0;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'd0);
    wr(2'd3, 8'd0);
    setsel(2'd3);
    sample();
    chk("R6 status clear at end", int'(bus_rdata), 0);
    chk("R9 irq low at end", irq_out ? 1 : 0, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule